// File: doc/BRIEF.md
# Cascaded Variable-Tap Delay Line

This block delays a single-bit serial stream by a programmable number of accepted beats, from 1 up to 16×N. The storage is a chain of N identical 16-stage shift segments that all run on one clock. Each segment exposes two outputs. The first is a tap picked by a 4-bit address. The second is its final stage, which feeds the serial input of the next segment. The delay code is split into two fields. The 4 low bits form a tap address that every segment shares. The remaining high bits select which segment's tap reaches the output.

Data enters as a stream. `din_valid` qualifies each beat, and a beat is taken on every rising clock edge where `din_valid` is high. The line applies no back-pressure and has no ready signal, because it can always accept. Cycles with `din_valid` low are gaps: nothing moves. The output does not pass through a register after the storage. It follows `dly` combinationally from the stored contents. The stored contents have no reset, so the line holds unknown values until 16×N beats have been accepted.

Top module: `cdl_top`

## Requirements
- R1: After each accepted beat, a delay code d gives a `dout` equal to the beat accepted d beats earlier. d=0 is the newest beat, so the total delay is d+1 beats.
- R2: `dly[3:0]` is the tap position inside a segment. `dly[DW-1:4]` is the segment index. A code is the sum 16×segment + position.
- R3: Delays of 16 or more beats reach the output through the chain of segments. The last stage of segment s feeds stage 0 of segment s+1, so the codes 15 and 16 give consecutive delays.
- R4: While `din_valid` is low, no stage shifts and `din` is ignored. For any `dly`, `dout` keeps the value it had before the gap.
- R5: A change on `dly` takes effect on `dout` in the same cycle, with no clock edge needed.
- R6: A segment index of N or more is treated as N-1. Such a code returns the same bit as the code 16×(N-1) + `dly[3:0]`.
- R7: Tap position 15 of any segment carries the same bit as that segment's cascade output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all segments |
| din_valid | input | 1 | Beat qualifier; high shifts the whole chain by one stage |
| din | input | 1 | Serial data bit |
| dly | input | DW = 4 + ceil(log2 N) | Delay code: total delay is dly+1 beats |
| dout | output | 1 | Delayed bit |

## Verification
The hardest case to reach is a delay that crosses one or more segment boundaries while valid gaps break up the input stream. The bench therefore primes all 16×N stages with a random bit pattern, inserting random gaps as it goes. After each later accepted beat it sweeps every delay code. That sweep includes the clamped codes beyond the last segment. The result is checked against a history of accepted beats, so the clamp, the cascade joins and the gap handling are all covered on the same stored contents.

// File: rtl/cdl_pkg.sv
`timescale 1ns/1ps
package cdl_pkg;
  localparam int SEG_DEPTH = 16;
  localparam int SEG_AW    = 4;

  function automatic int sel_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cdl_seg.sv
`timescale 1ns/1ps
module cdl_seg #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          en,
  input  logic          sin,
  input  logic [AW-1:0] addr,
  output logic          tap,
  output logic          cout
);
  logic [DEPTH-1:0] stages;

  always_ff @(posedge clk) begin
    if (en) stages <= {stages[DEPTH-2:0], sin};
  end

  assign tap  = stages[addr];
  assign cout = stages[DEPTH-1];
endmodule

// File: rtl/cdl_decode.sv
`timescale 1ns/1ps
module cdl_decode #(
  parameter int N    = 5,
  parameter int AW   = 4,
  parameter int SELW = 3,
  localparam int DW  = AW + SELW
) (
  input  logic [DW-1:0]   dly,
  output logic [AW-1:0]   addr,
  output logic [SELW-1:0] sel
);
  logic [SELW-1:0] sel_raw;

  assign addr    = dly[AW-1:0];
  assign sel_raw = dly[DW-1:AW];

  always_comb begin
    if (int'(sel_raw) >= N) sel = SELW'(N - 1);
    else                    sel = sel_raw;
  end
endmodule

// File: rtl/cdl_tapmux.sv
`timescale 1ns/1ps
module cdl_tapmux #(
  parameter int N    = 5,
  parameter int SELW = 3
) (
  input  logic [N-1:0]    taps,
  input  logic [SELW-1:0] sel,
  output logic            q
);
  logic [N-1:0] hit;

  for (genvar s = 0; s < N; s++) begin : g_hit
    assign hit[s] = (sel == SELW'(s));
  end

  assign q = |(hit & taps);
endmodule

// File: rtl/cdl_top.sv
`timescale 1ns/1ps
module cdl_top #(
  parameter int N = 5,
  localparam int AW   = cdl_pkg::SEG_AW,
  localparam int SELW = cdl_pkg::sel_width(N),
  localparam int DW   = AW + SELW
) (
  input  logic          clk,
  input  logic          din_valid,
  input  logic          din,
  input  logic [DW-1:0] dly,
  output logic          dout
);
  logic [AW-1:0]   addr;
  logic [SELW-1:0] sel;
  logic [N-1:0]    seg_tap;
  logic [N-1:0]    seg_cout;
  logic [N-1:0]    seg_in;

  cdl_decode #(.N(N), .AW(AW), .SELW(SELW)) dec_i (
    .dly(dly), .addr(addr), .sel(sel)
  );

  for (genvar s = 0; s < N; s++) begin : g_seg
    if (s == 0) begin : g_head
      assign seg_in[s] = din;
    end else begin : g_link
      assign seg_in[s] = seg_cout[s-1];
    end
    cdl_seg #(.DEPTH(cdl_pkg::SEG_DEPTH), .AW(AW)) seg_i (
      .clk(clk), .en(din_valid), .sin(seg_in[s]), .addr(addr),
      .tap(seg_tap[s]), .cout(seg_cout[s])
    );
  end

  cdl_tapmux #(.N(N), .SELW(SELW)) mux_i (
    .taps(seg_tap), .sel(sel), .q(dout)
  );
endmodule

// File: rtl/cdl_chk.sv
`timescale 1ns/1ps
module cdl_chk #(
  parameter int N  = 5,
  parameter int DW = 7
) (
  input logic          clk,
  input logic          shift_en,
  input logic          din,
  input logic [DW-1:0] dly,
  input logic          dout,
  input logic [N-1:0]  taps,
  input logic [N-1:0]  cascs
);
  localparam int FILL = 16 * N;
  int   beats = 0;
  logic primed;

  always_ff @(posedge clk) begin
    if (shift_en === 1'b1 && beats < FILL) beats <= beats + 1;
  end
  assign primed = (beats >= FILL);

  // R1: address 0 of the first segment holds the last accepted bit
  a_r1_newest: assert property (@(posedge clk) disable iff (!primed)
    (shift_en && dly[3:0] == 4'd0) |=> (dly[3:0] != 4'd0 || taps[0] == $past(din)));

  // R3: each segment's first stage takes the previous segment's last stage
  for (genvar s = 1; s < N; s++) begin : g_link
    a_r3_cascade: assert property (@(posedge clk) disable iff (!primed)
      (shift_en && dly[3:0] == 4'd0) |=> (dly[3:0] != 4'd0 || taps[s] == $past(cascs[s-1])));
  end

  // R4: no enable, no movement
  a_r4_hold: assert property (@(posedge clk) disable iff (!primed)
    !shift_en |=> (!$stable(dly[3:0]) || $stable(taps)));

  // R7: position 15 equals the cascade output
  a_r7_last_tap: assert property (@(posedge clk) disable iff (!primed)
    (dly[3:0] == 4'hf) |-> (taps == cascs));

  // R6: out-of-range segment index clamps to the last segment
  a_r6_clamp: assert property (@(posedge clk) disable iff (!primed)
    (int'(dly[DW-1:4]) >= N) |-> (dout == taps[N-1]));
endmodule

bind cdl_top cdl_chk #(.N(N), .DW(DW)) chk_i (
  .clk(clk), .shift_en(din_valid), .din(din), .dly(dly), .dout(dout),
  .taps(seg_tap), .cascs(seg_cout)
);

// File: tb/cdl_top_tb_top.sv
`timescale 1ns/1ps
module cdl_top_tb_top;
  localparam int N    = 5;
  localparam int SELW = cdl_pkg::sel_width(N);
  localparam int DW   = 4 + SELW;
  localparam int TOT  = 16 * N;

  logic          clk = 1'b0;
  logic          din_valid = 1'b0;
  logic          din = 1'b0;
  logic [DW-1:0] dly = '0;
  logic          dout;

  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  logic hist[$];   // accepted beats, newest at index 0

  always #2.5 clk = ~clk;   // 200 MHz

  cdl_top #(.N(N)) dut_i (
    .clk(clk), .din_valid(din_valid), .din(din), .dly(dly), .dout(dout)
  );

  task automatic check(input string req, input logic got, input logic exp, input int code);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s dly=%0d got=%b expected=%b", req, code, got, exp);
    end
  endtask

  // driver: present one cycle of input, record the beat if accepted
  task automatic step(input bit v, input bit b);
    din_valid = v;
    din = b;
    @(posedge clk);
    #0.5;
    if (v) begin
      hist.push_front(b);
      if (hist.size() > TOT) void'(hist.pop_back());
    end
  endtask

  // monitor: sweep every code against the history
  task automatic sweep(input string req);
    for (int d = 0; d < TOT; d++) begin
      dly = DW'(d);
      #0.01;
      check(d < 16 ? {req, "/R1"} : {req, "/R2/R3"}, dout, hist[d], d);
    end
    for (int s = N; s < (1 << SELW); s++) begin
      for (int a = 0; a < 16; a++) begin
        dly = DW'(s * 16 + a);
        #0.01;
        check("R6", dout, hist[16 * (N - 1) + a], s * 16 + a);
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // prime all stages with random gaps
    while (hist.size() < TOT) begin
      step(($urandom % 4) != 0, 1'($urandom));
    end
    sweep("R1");
    // R7 / R3 boundary: code 15 and 16 are consecutive delays
    dly = DW'(15); #0.01; check("R7", dout, hist[15], 15);
    dly = DW'(16); #0.01; check("R3", dout, hist[16], 16);
    // R5: dly change alone moves dout, no edge in between
    dly = DW'(TOT - 1); #0.01; check("R5", dout, hist[TOT - 1], TOT - 1);
    dly = DW'(0);       #0.01; check("R5", dout, hist[0], 0);
    // running stream with random gaps
    for (int i = 0; i < 40; i++) begin
      bit v = ($urandom % 3) != 0;
      step(v, 1'($urandom));
      sweep(v ? "R1" : "R4");
    end
    // R4: long gap with toggling din, contents must not move
    for (int i = 0; i < 4; i++) begin
      step(1'b0, i[0]);
    end
    sweep("R4");
    // alternating pattern for full-depth check
    for (int i = 0; i < TOT; i++) begin
      step(1'b1, i[0]);
    end
    sweep("R2");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule